// File: doc/BRIEF.md
# Four-Lane Banked Round-Robin Serializer

This block takes a parallel stream that carries one sample per lane on every beat and turns it into a stream of one sample per beat. Every lane writes into its own FIFO bank, so each bank takes at most one write per clock and can sit in a plain dual-port memory. A sequencer reads the banks in fixed rotation, starting at bank 0. Because bin `k` of a frame arrives on lane `k mod LANES`, this rotation puts the bins back in ascending order.

Every stored word carries a frame-end flag in its least significant bit. The flag is set only on the last lane's word of a beat that was written with `in_last`. After the output multiplexer the flag is split off and drives `m_tlast`. The 50-bit sample is zero-extended to 64 bits.

The input side uses valid/ready handshaking. `in_ready` is low while any bank is full, and a beat is taken only on a clock where `in_valid` and `in_ready` are both high. If a beat is offered while `in_ready` is low, the block raises `overflow` for one cycle.

The output side follows AXI4-Stream rules:
- A sample moves on a clock where `m_tvalid` and `m_tready` are both high.
- While `m_tready` is low, the presented sample holds and incoming beats pile up in the banks.
- A rotation starts at bank 0 only when every bank holds data. Once started, each later step needs only its own bank to be non-empty.

Top module: `lane_rr_serializer`

## Requirements
- R1: After reset, `m_tvalid` is 0, `in_ready` is 1, `overflow` is 0, and the first sample presented comes from lane 0.
- R2: Lane `n` of `in_data` is the slice `[n*50 +: 50]`. The samples of each accepted beat leave in lane order 0, 1, 2, 3. Successive beats leave in the order they were accepted, so bins come out in natural order.
- R3: Each lane slice holds the real part in bits 24:0 and the imaginary part in bits 49:25. `m_tdata` carries the real part in bits 24:0 and the imaginary part in bits 49:25. Bits 63:50 of `m_tdata` are 0.
- R4: `m_tlast` is 1 only on the lane-3 sample of a beat accepted with `in_last`=1. It is 0 on the samples of lanes 0 to 2, and on every sample of a beat accepted with `in_last`=0.
- R5: When no sample is buffered, `m_tvalid` is 0. At lane 0, `m_tvalid` rises once every bank holds data. Within a rotation, the lane 1 to 3 samples stay valid even though bank 0 is already empty.
- R6: While `m_tvalid`=1 and `m_tready`=0, `m_tvalid` stays 1 on the next cycle, and `m_tdata` and `m_tlast` do not change.
- R7: After 128 beats are accepted with no reads, `in_ready` is 0. A beat offered while `in_ready`=0 is discarded and never appears at the output.
- R8: `overflow` is 1 in the cycle after a clock at which `in_valid`=1 and `in_ready`=0. Otherwise it is 0.
- R9: With `m_tready` held at 1 and data buffered, one sample is accepted on every clock, with no bubbles within or between beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken (no bank full) |
| in_data | input | 200 | Four 50-bit lane samples, lane n in bits [n*50 +: 50] |
| in_last | input | 1 | Beat is the last of its frame |
| m_tvalid | output | 1 | Output sample valid |
| m_tready | input | 1 | Downstream can take the sample |
| m_tdata | output | 64 | Zero-extended sample, real in 24:0, imaginary in 49:25 |
| m_tlast | output | 1 | Sample is the final bin of the frame |
| overflow | output | 1 | A beat was offered while the banks were full, one cycle late |

## Verification
The assertions check the following on every cycle:
- The held sample stays stable under back-pressure.
- `m_tlast` appears only at the last rotation slot.
- The buffered sample count, tracked from the handshakes alone, never exceeds the total bank capacity.
- `in_ready` drops at full capacity, and `m_tvalid` stays low when nothing is buffered.

Only the bench scenarios can show the following:
- Lane-to-bin ordering and the field packing of `m_tdata`.
- That a beat discarded while full never surfaces after the drain.
- Back-to-back throughput and the overflow pulse timing.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int LRS_LANES   = 4;
  localparam int LRS_DEPTH   = 128;
  localparam int LRS_HALF_W  = 25;
  localparam int LRS_TDATA_W = 64;

  function automatic int lrs_next_lane(input int cur, input int lanes);
    return (cur == lanes - 1) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/lrs_lane_fifo.sv
module lrs_lane_fifo #(
  parameter int W     = 51,
  parameter int DEPTH = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_idx;
  logic [AW-1:0] rd_idx;
  logic [CW-1:0] count;
  logic          do_push;
  logic          do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
      end
      if (do_pop) begin
        rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
      end
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/lrs_rr_seq.sv
module lrs_rr_seq #(
  parameter int LANES = 4,
  localparam int PW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] bank_empty,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [PW-1:0]    ptr,
  output logic [LANES-1:0] pop
);
  import lrs_pkg::*;

  logic fire;

  always_comb begin
    if (ptr == '0) begin
      out_valid = ~|bank_empty;
    end else begin
      out_valid = !bank_empty[ptr];
    end
  end

  assign fire = out_valid && out_ready;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_pop
      assign pop[g] = fire && (ptr == PW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (fire) begin
      ptr <= PW'(lrs_next_lane(int'(ptr), LANES));
    end
  end
endmodule

// File: rtl/lrs_out_pack.sv
module lrs_out_pack #(
  parameter int LANES   = 4,
  parameter int WORD_W  = 51,
  parameter int TDATA_W = 64,
  localparam int PW     = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int DATA_W = WORD_W - 1
) (
  input  logic [LANES*WORD_W-1:0] words,
  input  logic [PW-1:0]           ptr,
  input  logic                    valid,
  output logic [TDATA_W-1:0]      tdata,
  output logic                    tlast
);
  logic [WORD_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < LANES; i++) begin
      if (ptr == PW'(i)) begin
        sel = words[i*WORD_W +: WORD_W];
      end
    end
  end

  assign tdata = {{(TDATA_W-DATA_W){1'b0}}, sel[WORD_W-1:1]};
  assign tlast = valid && sel[0];
endmodule

// File: rtl/lane_rr_serializer.sv
module lane_rr_serializer #(
  parameter int LANES    = lrs_pkg::LRS_LANES,
  parameter int DEPTH    = lrs_pkg::LRS_DEPTH,
  parameter int HALF_W   = lrs_pkg::LRS_HALF_W,
  parameter int TDATA_W  = lrs_pkg::LRS_TDATA_W,
  localparam int DATA_W  = 2 * HALF_W,
  localparam int WORD_W  = DATA_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*DATA_W-1:0] in_data,
  input  logic                    in_last,
  output logic                    m_tvalid,
  input  logic                    m_tready,
  output logic [TDATA_W-1:0]      m_tdata,
  output logic                    m_tlast,
  output logic                    overflow
);
  localparam int PW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES-1:0]        bank_empty;
  logic [LANES-1:0]        bank_full;
  logic [LANES-1:0]        bank_pop;
  logic [LANES*WORD_W-1:0] bank_words;
  logic [PW-1:0]           rd_ptr;
  logic                    wr_fire;

  assign in_ready = ~|bank_full;
  assign wr_fire  = in_valid && in_ready;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_bank
      logic [WORD_W-1:0] wword;
      logic              flag;
      if (g == LANES - 1) begin : g_flag_last
        assign flag = in_last;
      end else begin : g_flag_zero
        assign flag = 1'b0;
      end
      assign wword = {in_data[g*DATA_W +: DATA_W], flag};

      lrs_lane_fifo #(
        .W     (WORD_W),
        .DEPTH (DEPTH)
      ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_fire),
        .wdata (wword),
        .pop   (bank_pop[g]),
        .rdata (bank_words[g*WORD_W +: WORD_W]),
        .empty (bank_empty[g]),
        .full  (bank_full[g])
      );
    end
  endgenerate

  lrs_rr_seq #(
    .LANES (LANES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_empty (bank_empty),
    .out_ready  (m_tready),
    .out_valid  (m_tvalid),
    .ptr        (rd_ptr),
    .pop        (bank_pop)
  );

  lrs_out_pack #(
    .LANES   (LANES),
    .WORD_W  (WORD_W),
    .TDATA_W (TDATA_W)
  ) u_pack (
    .words (bank_words),
    .ptr   (rd_ptr),
    .valid (m_tvalid),
    .tdata (m_tdata),
    .tlast (m_tlast)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overflow <= 1'b0;
    end else begin
      overflow <= in_valid && !in_ready;
    end
  end
endmodule

// File: rtl/lane_rr_serializer_chk.sv
module lane_rr_serializer_chk #(
  parameter int LANES   = 4,
  parameter int DEPTH   = 128,
  parameter int TDATA_W = 64,
  localparam int PW     = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int OW     = $clog2(LANES * DEPTH + 1) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               m_tvalid,
  input logic               m_tready,
  input logic               m_tlast,
  input logic [TDATA_W-1:0] m_tdata,
  input logic [PW-1:0]      rd_ptr
);
  localparam logic [OW-1:0] CAP = OW'(LANES * DEPTH);

  logic [OW-1:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      occ <= occ + ((in_valid && in_ready) ? OW'(LANES) : '0)
                 - ((m_tvalid && m_tready) ? OW'(1) : '0);
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  p_tlast_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_tlast |-> (m_tvalid && rd_ptr == PW'(LANES - 1)));

  p_capacity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CAP);

  p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CAP) |-> !in_ready);

  p_empty_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !m_tvalid);
endmodule

bind lane_rr_serializer lane_rr_serializer_chk #(
  .LANES   (LANES),
  .DEPTH   (DEPTH),
  .TDATA_W (TDATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready),
  .m_tlast  (m_tlast),
  .m_tdata  (m_tdata),
  .rd_ptr   (rd_ptr)
);

// File: tb/lane_rr_serializer_tb.sv
module lane_rr_serializer_tb;
  localparam int LANES = 4;
  localparam int DEPTH = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [199:0] in_data = '0;
  logic         in_last = 1'b0;
  logic         m_tvalid;
  logic         m_tready = 1'b0;
  logic [63:0]  m_tdata;
  logic         m_tlast;
  logic         overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lane_rr_serializer u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_last  (in_last),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast),
    .overflow (overflow)
  );

  // vector: {real seed[24:0], imag seed[24:0], last}
  localparam logic [50:0] VEC [0:7] = '{
    {25'h0000000, 25'h0000000, 1'b0},
    {25'h1FFFFF0, 25'h0000011, 1'b1},
    {25'h0ABCDE0, 25'h1234560, 1'b0},
    {25'h1555550, 25'h0AAAAA0, 1'b1},
    {25'h0000100, 25'h1FFFFFC, 1'b0},
    {25'h0F0F0F0, 25'h00F0F00, 1'b0},
    {25'h1000000, 25'h0000001, 1'b1},
    {25'h0777770, 25'h1888880, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [49:0] lane_sample(input logic [24:0] re, input logic [24:0] im);
    return {im, re};
  endfunction

  task automatic write_beat(input logic [199:0] d, input logic last);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_last  = last;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic pull(input logic [49:0] exp_s, input logic exp_last, input string tag);
    @(negedge clk);
    m_tready = 1'b1;
    #0;
    check(m_tvalid === 1'b1, {tag, " tvalid"}, {63'd0, m_tvalid}, 64'd1);
    check(m_tdata === {14'd0, exp_s}, {tag, " tdata"}, m_tdata, {14'd0, exp_s});
    check(m_tlast === exp_last, {tag, " tlast"}, {63'd0, m_tlast}, {63'd0, exp_last});
    @(posedge clk);
  endtask

  task automatic idle_ready;
    @(negedge clk);
    m_tready = 1'b0;
  endtask

  function automatic logic [199:0] fill_beat(input int b);
    logic [199:0] d;
    for (int n = 0; n < LANES; n++) begin
      d[n*50 +: 50] = lane_sample(25'(b*4 + n), 25'(25'h1ABCD ^ (b*4 + n)));
    end
    return d;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(m_tvalid === 1'b0, "R1 tvalid", {63'd0, m_tvalid}, 64'd0);
    check(in_ready === 1'b1, "R1 in_ready", {63'd0, in_ready}, 64'd1);
    check(overflow === 1'b0, "R1 overflow", {63'd0, overflow}, 64'd0);

    // Vector table: R2 lane order, R3 packing, R4 tlast placement
    for (int v = 0; v < 8; v++) begin
      logic [199:0] d;
      logic [24:0] re;
      logic [24:0] im;
      re = VEC[v][50:26];
      im = VEC[v][25:1];
      for (int n = 0; n < LANES; n++) begin
        d[n*50 +: 50] = lane_sample(re + 25'(n), im ^ 25'(n * 3));
      end
      write_beat(d, VEC[v][0]);
      for (int n = 0; n < LANES; n++) begin
        pull(lane_sample(re + 25'(n), im ^ 25'(n * 3)),
             (n == LANES - 1) ? VEC[v][0] : 1'b0,
             $sformatf("R2 R3 R4 vec%0d lane%0d", v, n));
      end
      idle_ready();
    end

    // R5: empty gives no valid; mid-rotation lanes stay valid
    #0;
    check(m_tvalid === 1'b0, "R5 empty tvalid", {63'd0, m_tvalid}, 64'd0);
    write_beat(fill_beat(7), 1'b0);
    @(negedge clk);
    check(m_tvalid === 1'b1, "R5 all banks tvalid", {63'd0, m_tvalid}, 64'd1);
    pull(fill_beat(7)[49:0], 1'b0, "R5 lane0");
    idle_ready();
    #0;
    check(m_tvalid === 1'b1, "R5 mid rotation tvalid", {63'd0, m_tvalid}, 64'd1);
    for (int n = 1; n < LANES; n++) begin
      pull(fill_beat(7)[n*50 +: 50], 1'b0, "R5 rest");
    end
    idle_ready();
    #0;
    check(m_tvalid === 1'b0, "R5 drained tvalid", {63'd0, m_tvalid}, 64'd0);

    // R6: back-pressure hold
    write_beat(fill_beat(9), 1'b1);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(m_tvalid === 1'b1 && m_tdata === {14'd0, fill_beat(9)[49:0]},
            "R6 hold", m_tdata, {14'd0, fill_beat(9)[49:0]});
    end
    for (int n = 0; n < LANES; n++) begin
      pull(fill_beat(9)[n*50 +: 50], n == LANES - 1, "R6 release");
    end
    idle_ready();

    // R7 fill to capacity, R8 overflow on rejected beat
    for (int b = 0; b < DEPTH; b++) begin
      @(negedge clk);
      if (in_ready !== 1'b1) begin
        check(1'b0, "R7 ready during fill", {63'd0, in_ready}, 64'd1);
      end
      write_beat(fill_beat(b), b == DEPTH - 1);
    end
    @(negedge clk);
    check(in_ready === 1'b0, "R7 full in_ready", {63'd0, in_ready}, 64'd0);
    check(overflow === 1'b0, "R8 no overflow yet", {63'd0, overflow}, 64'd0);
    in_valid = 1'b1;
    in_data  = {4{50'h3_DEAD_BEEF_0000}};
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    @(negedge clk);
    check(overflow === 1'b1, "R8 overflow pulse", {63'd0, overflow}, 64'd1);
    @(negedge clk);
    check(overflow === 1'b0, "R8 overflow clears", {63'd0, overflow}, 64'd0);

    // R9 drain back-to-back, order and single tlast on bin 511
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH * LANES; i++) begin
        logic [199:0] d;
        logic [49:0] es;
        logic el;
        d  = fill_beat(i / LANES);
        es = d[(i % LANES)*50 +: 50];
        el = (i == DEPTH * LANES - 1);
        @(negedge clk);
        m_tready = 1'b1;
        #0;
        if (m_tvalid !== 1'b1 || m_tdata !== {14'd0, es} || m_tlast !== el) begin
          bad++;
          if (bad < 4) begin
            $display("FAIL R9 R2 drain bin %0d actual=%h/%b expected=%h/%b", i, m_tdata, m_tlast, es, el);
          end
        end
        @(posedge clk);
      end
      checks++;
      if (bad != 0) fails++;
    end
    idle_ready();
    #0;
    check(m_tvalid === 1'b0, "R7 rejected beat absent", {63'd0, m_tvalid}, 64'd0);
    check(in_ready === 1'b1, "R7 ready after drain", {63'd0, in_ready}, 64'd1);

    // R1 reset mid-stream returns to lane 0
    write_beat(fill_beat(3), 1'b0);
    pull(fill_beat(3)[49:0], 1'b0, "R1 pre-reset");
    idle_ready();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #0;
    check(m_tvalid === 1'b0, "R1 reset clears", {63'd0, m_tvalid}, 64'd0);
    write_beat(fill_beat(5), 1'b0);
    pull(fill_beat(5)[49:0], 1'b0, "R1 lane0 after reset");
    idle_ready();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule